// File: doc/BRIEF.md
# Wired-Interrupt Message Gateway

This block collects up to `NUM_SRC` wired interrupt lines (63 by default, at most 1023) and turns them into identity-tagged interrupt messages for a hart. Every line is identified by a number from 1 to `NUM_SRC`. Identity 0 is never a source, and identity k uses configuration slot k-1. Software gives each source a 3-bit mode that selects how its wire is read: ignored, detached, rising or falling edge, or high or low level. Software also gives each source a target hart number and switches the source on through a set-enable-by-number port.

A domain register holds two bits: a global enable and a delivery-mode bit. Messages flow only when both bits are 1. A source that is pending, is enabled and has an active mode becomes a candidate. The gateway sends the candidate with the lowest identity on a valid/ready output as a pair of identity and target hart. Back-pressure rules: once `msg_valid` rises, `msg_id` and `msg_hart` stay frozen until a cycle in which `msg_ready` is high. That handshake clears the source's pending state. `msg_valid` then stays low for exactly one cycle while the next candidate is chosen. A consumer may hold `msg_ready` high at all times, or raise it whenever it likes.

Top module: `irq_gateway`

## Requirements
- R1: Source mode encoding is 0 off, 1 detached, 4 rising edge, 5 falling edge, 6 level high, 7 level low. A written value of 2 or 3 is stored as 0 and reads back as 0 on `rd_mode`.
- R2: Identities 1..NUM_SRC address slots 0..NUM_SRC-1. A write of identity 0, or of any identity above NUM_SRC, on the config, set-enable or set-pending port changes nothing. Reads of such identities return mode 0 and enable 0. The highest identity, NUM_SRC, works like any other.
- R3: A write of identity k on the set-enable port sets the enable bit of source k. A disabled source is never sent, but its edge pending state is kept and is sent once the source is enabled.
- R4: No message starts unless the domain global enable bit and the delivery-mode bit are both 1. Pending state held while either bit is 0 is sent after both become 1.
- R5: In rising-edge mode (4), a 0-to-1 change on the two-flop synchronised wire latches pending. The result is exactly one message per edge, and `msg_valid` rises on the 4th clock edge after the wire changes.
- R6: In falling-edge mode (5), a 1-to-0 change latches pending. Rising changes do nothing.
- R7: In level modes (6 high, 7 low), a source is a candidate while its wire is at the active level. After its message is accepted, no further message is sent until the wire leaves the active level and returns to it.
- R8: In detached mode (1), the wire is ignored. A write of identity k on the set-pending port latches pending for source k. The set-pending port has no effect on sources that are in any other mode.
- R9: A source in mode 0 (or in a reserved mode) never produces a message, whatever its wire or the set-pending port does.
- R10: When several sources are candidates, the lowest identity is sent first.
- R11: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_id` and `msg_hart` hold. After an accepted message, `msg_valid` is low for one cycle.
- R12: `msg_hart` carries the target hart that was configured for the source named in `msg_id`.
- R13: After reset, `msg_valid` is 0 and every source reads back mode 0 and enable 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Raw interrupt wires; bit k-1 is identity k |
| cfg_we | input | 1 | Write strobe for a source's mode and target hart |
| cfg_id | input | IDW | Identity written by `cfg_we` |
| cfg_mode | input | 3 | Source mode value (R1 encoding) |
| cfg_hart | input | HART_W | Target hart for the source |
| en_set_we | input | 1 | Set-enable-by-number strobe |
| en_set_id | input | IDW | Identity to enable |
| pend_set_we | input | 1 | Set-pending-by-number strobe |
| pend_set_id | input | IDW | Identity to make pending |
| dom_we | input | 1 | Domain register write strobe |
| dom_ie | input | 1 | Global enable value |
| dom_msi | input | 1 | Delivery-mode value; 1 selects messages |
| rd_id | input | IDW | Identity whose configuration is shown |
| rd_mode | output | 3 | Stored mode of `rd_id` |
| rd_en | output | 1 | Enable bit of `rd_id` |
| msg_valid | output | 1 | Message present |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_id | output | IDW | Identity of the message |
| msg_hart | output | HART_W | Target hart of the message |

## Verification
Each result has a fixed latency, counted in clock edges from the edge that samples the stimulus. A port write (set-enable, set-pending or domain) raises `msg_valid` on the 2nd edge. A level wire does so on the 3rd edge and an edge wire on the 4th. After a handshake, `msg_valid` is low for one cycle. The bench drives every input just after a rising edge and samples just before the next rising edge. Latency checks count edges from the drive and look once before the due edge and once after it. The checks that a message must not appear wait at least six cycles, which is longer than the slowest path. Every accepted message is compared, in order, against an expected queue that the stimulus tasks fill.

// File: rtl/irq_gw_pkg.sv
package irq_gw_pkg;

  typedef enum logic [2:0] {
    SM_OFF    = 3'd0,
    SM_DETACH = 3'd1,
    SM_RISE   = 3'd4,
    SM_FALL   = 3'd5,
    SM_HIGH   = 3'd6,
    SM_LOW    = 3'd7
  } src_mode_e;

  // Reserved codes collapse to off so that they read back as 0.
  function automatic src_mode_e sanitize_mode(input logic [2:0] raw);
    case (raw)
      3'd1:    return SM_DETACH;
      3'd4:    return SM_RISE;
      3'd5:    return SM_FALL;
      3'd6:    return SM_HIGH;
      3'd7:    return SM_LOW;
      default: return SM_OFF;
    endcase
  endfunction

endpackage

// File: rtl/irq_gw_cell.sv
module irq_gw_cell
  import irq_gw_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wire_i,
  input  src_mode_e mode_i,
  input  logic      mode_wr_i,
  input  logic      swpend_i,
  input  logic      fwd_i,
  output logic      req_o
);

  logic sync1_q, sync2_q, hist_q;
  logic pend_q, sent_q;
  logic is_level, lvl_act, rise_ev, fall_ev;

  assign rise_ev  = sync2_q & ~hist_q;
  assign fall_ev  = ~sync2_q & hist_q;
  assign is_level = (mode_i == SM_HIGH) || (mode_i == SM_LOW);
  assign lvl_act  = (mode_i == SM_HIGH) ? sync2_q :
                    (mode_i == SM_LOW)  ? ~sync2_q : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      hist_q  <= 1'b0;
      pend_q  <= 1'b0;
      sent_q  <= 1'b0;
    end else begin
      sync1_q <= wire_i;
      sync2_q <= sync1_q;
      hist_q  <= sync2_q;
      if (mode_wr_i) begin
        pend_q <= 1'b0;
        sent_q <= 1'b0;
      end else begin
        case (mode_i)
          SM_RISE: begin
            if (rise_ev)    pend_q <= 1'b1;
            else if (fwd_i) pend_q <= 1'b0;
          end
          SM_FALL: begin
            if (fall_ev)    pend_q <= 1'b1;
            else if (fwd_i) pend_q <= 1'b0;
          end
          SM_DETACH: begin
            if (swpend_i)   pend_q <= 1'b1;
            else if (fwd_i) pend_q <= 1'b0;
          end
          SM_HIGH, SM_LOW: begin
            pend_q <= 1'b0;
            if (!lvl_act)   sent_q <= 1'b0;
            else if (fwd_i) sent_q <= 1'b1;
          end
          default: begin
            pend_q <= 1'b0;
            sent_q <= 1'b0;
          end
        endcase
      end
    end
  end

  always_comb begin
    if (is_level) req_o = lvl_act & ~sent_q;
    else          req_o = pend_q;
  end

  // R9: an off source holds no pending state and raises no request
  p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == SM_OFF) |-> (!pend_q && !req_o));

  // R5: latched edge pending survives until forwarded or reconfigured
  p_edge_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == SM_RISE || mode_i == SM_FALL) && pend_q && !fwd_i && !mode_wr_i)
      |=> pend_q);

  // R7: an accepted level request is not repeated on the next cycle
  p_level_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_level && fwd_i && lvl_act && !mode_wr_i) |=> !req_o);

endmodule

// File: rtl/irq_gw_pick.sv
module irq_gw_pick #(
  parameter int N  = 63,
  parameter int SW = 6
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [SW-1:0] slot_o
);

  always_comb begin
    any_o  = |req_i;
    slot_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) slot_o = SW'(k);
    end
  end

endmodule

// File: rtl/irq_gw_issue.sv
module irq_gw_issue #(
  parameter int N      = 63,
  parameter int IDW    = 6,
  parameter int HART_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_i,
  input  logic              any_i,
  input  logic [IDW-1:0]    id_i,
  input  logic [HART_W-1:0] hart_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [IDW-1:0]    id_o,
  output logic [HART_W-1:0] hart_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      id_o    <= '0;
      hart_o  <= '0;
    end else if (!valid_o) begin
      if (gate_i && any_i) begin
        valid_o <= 1'b1;
        id_o    <= id_i;
        hart_o  <= hart_i;
      end
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  // R11: stalled message stays put
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(id_o) && $stable(hart_o)));

  // R11: one idle cycle after every accepted message
  p_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready_i) |=> !valid_o);

  // R4: a message only starts while the domain allows delivery
  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(gate_i));

  // R2: the identity on the output is always a real source
  p_id_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (id_o != '0 && id_o <= IDW'(N)));

endmodule

// File: rtl/irq_gateway.sv
module irq_gateway
  import irq_gw_pkg::*;
#(
  parameter  int NUM_SRC = 63,
  parameter  int HART_W  = 6,
  localparam int IDW     = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               cfg_we,
  input  logic [IDW-1:0]     cfg_id,
  input  logic [2:0]         cfg_mode,
  input  logic [HART_W-1:0]  cfg_hart,
  input  logic               en_set_we,
  input  logic [IDW-1:0]     en_set_id,
  input  logic               pend_set_we,
  input  logic [IDW-1:0]     pend_set_id,
  input  logic               dom_we,
  input  logic               dom_ie,
  input  logic               dom_msi,
  input  logic [IDW-1:0]     rd_id,
  output logic [2:0]         rd_mode,
  output logic               rd_en,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [IDW-1:0]     msg_id,
  output logic [HART_W-1:0]  msg_hart
);

  localparam int SW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  src_mode_e          mode_q [NUM_SRC];
  logic [HART_W-1:0]  hart_q [NUM_SRC];
  logic [NUM_SRC-1:0] en_q;
  logic               ie_q, msi_q;

  logic [NUM_SRC-1:0] mode_wr, swpend, fwd, req, cand;
  logic               hs, pick_any;
  logic [SW-1:0]      pick_slot;
  logic [IDW-1:0]     pick_id;
  logic [HART_W-1:0]  pick_hart;

  assign hs = msg_valid & msg_ready;

  // Per-slot strobes decoded from identity numbers; 0 and >NUM_SRC hit nothing.
  always_comb begin
    for (int k = 0; k < NUM_SRC; k++) begin
      mode_wr[k] = cfg_we      && (cfg_id      == IDW'(k + 1));
      swpend[k]  = pend_set_we && (pend_set_id == IDW'(k + 1));
      fwd[k]     = hs          && (msg_id      == IDW'(k + 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_SRC; k++) begin
        mode_q[k] <= SM_OFF;
        hart_q[k] <= '0;
      end
      en_q  <= '0;
      ie_q  <= 1'b0;
      msi_q <= 1'b0;
    end else begin
      for (int k = 0; k < NUM_SRC; k++) begin
        if (mode_wr[k]) begin
          mode_q[k] <= sanitize_mode(cfg_mode);
          hart_q[k] <= cfg_hart;
        end
        if (en_set_we && (en_set_id == IDW'(k + 1))) en_q[k] <= 1'b1;
      end
      if (dom_we) begin
        ie_q  <= dom_ie;
        msi_q <= dom_msi;
      end
    end
  end

  always_comb begin
    rd_mode = 3'd0;
    rd_en   = 1'b0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (rd_id == IDW'(k + 1)) begin
        rd_mode = mode_q[k];
        rd_en   = en_q[k];
      end
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    irq_gw_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .wire_i    (src_i[g]),
      .mode_i    (mode_q[g]),
      .mode_wr_i (mode_wr[g]),
      .swpend_i  (swpend[g]),
      .fwd_i     (fwd[g]),
      .req_o     (req[g])
    );
  end

  assign cand = req & en_q;

  irq_gw_pick #(.N(NUM_SRC), .SW(SW)) u_pick (
    .req_i  (cand),
    .any_o  (pick_any),
    .slot_o (pick_slot)
  );

  assign pick_id   = IDW'(pick_slot) + IDW'(1);
  assign pick_hart = hart_q[pick_slot];

  irq_gw_issue #(.N(NUM_SRC), .IDW(IDW), .HART_W(HART_W)) u_issue (
    .clk     (clk),
    .rst_n   (rst_n),
    .gate_i  (ie_q & msi_q),
    .any_i   (pick_any),
    .id_i    (pick_id),
    .hart_i  (pick_hart),
    .ready_i (msg_ready),
    .valid_o (msg_valid),
    .id_o    (msg_id),
    .hart_o  (msg_hart)
  );

  // R1: a reserved mode code never reaches the stored configuration
  p_no_reserved_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (rd_id != $past(cfg_id) || (rd_mode != 3'd2 && rd_mode != 3'd3)));

  // R3: enable bits only ever get set
  p_enable_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones($past(en_q)) <= $countones(en_q));

endmodule

// File: tb/irq_gateway_bench.sv
module irq_gateway_bench;

  localparam int CLK_P  = 10;
  localparam int N      = 12;
  localparam int HW     = 3;
  localparam int IDW    = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   src = '0;
  logic           cfg_we = 0, en_set_we = 0, pend_set_we = 0, dom_we = 0;
  logic [IDW-1:0] cfg_id = '0, en_set_id = '0, pend_set_id = '0, rd_id = '0;
  logic [2:0]     cfg_mode = '0;
  logic [HW-1:0]  cfg_hart = '0;
  logic           dom_ie = 0, dom_msi = 0, msg_ready = 0;
  logic [2:0]     rd_mode;
  logic           rd_en, msg_valid;
  logic [IDW-1:0] msg_id;
  logic [HW-1:0]  msg_hart;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct { int id; int hart; string tag; } exp_t;
  exp_t exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  irq_gateway #(.NUM_SRC(N), .HART_W(HW)) u_irq_gateway (
    .clk(clk), .rst_n(rst_n), .src_i(src),
    .cfg_we(cfg_we), .cfg_id(cfg_id), .cfg_mode(cfg_mode), .cfg_hart(cfg_hart),
    .en_set_we(en_set_we), .en_set_id(en_set_id),
    .pend_set_we(pend_set_we), .pend_set_id(pend_set_id),
    .dom_we(dom_we), .dom_ie(dom_ie), .dom_msi(dom_msi),
    .rd_id(rd_id), .rd_mode(rd_mode), .rd_en(rd_en),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_id(msg_id), .msg_hart(msg_hart)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_msg(input int id, input int hart, input string tag);
    exp_t e;
    e.id = id; e.hart = hart; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wr_cfg(input int id, input int mode, input int hart);
    cfg_we = 1; cfg_id = IDW'(id); cfg_mode = 3'(mode); cfg_hart = HW'(hart);
    step();
    cfg_we = 0;
  endtask

  task automatic set_en(input int id);
    en_set_we = 1; en_set_id = IDW'(id);
    step();
    en_set_we = 0;
  endtask

  task automatic set_pend(input int id);
    pend_set_we = 1; pend_set_id = IDW'(id);
    step();
    pend_set_we = 0;
  endtask

  task automatic wr_dom(input bit ie, input bit msi);
    dom_we = 1; dom_ie = ie; dom_msi = msi;
    step();
    dom_we = 0;
  endtask

  task automatic chk_mode(input int id, input int expv, input string tag);
    rd_id = IDW'(id);
    #1;
    chk(rd_mode == 3'(expv), tag, rd_mode, expv);
  endtask

  task automatic chk_quiet(input string tag);
    @(negedge clk);
    chk(msg_valid == 1'b0, tag, msg_valid, 0);
    step();
  endtask

  // Scoreboard monitor: every accepted message is compared against the queue.
  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, "R12 unexpected message", int'(msg_id), 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(int'(msg_id) == e.id, {e.tag, " id"}, msg_id, e.id);
        chk(int'(msg_hart) == e.hart, {e.tag, " R12 hart"}, msg_hart, e.hart);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step();

    // R13 reset state
    @(negedge clk);
    chk(msg_valid == 1'b0, "R13 valid", msg_valid, 0);
    rd_id = 4'd1; #1;
    chk(rd_mode == 3'd0, "R13 mode", rd_mode, 0);
    chk(rd_en == 1'b0, "R13 enable", rd_en, 0);
    step();

    wr_dom(1, 1);

    // R1 encodings and reserved collapse
    wr_cfg(2, 3, 1);
    chk_mode(2, 0, "R1 reserved 3");
    wr_cfg(2, 2, 1);
    chk_mode(2, 0, "R1 reserved 2");
    wr_cfg(2, 5, 1);
    chk_mode(2, 5, "R1 falling");

    // R3 + R5: rising edge held while disabled
    msg_ready = 0;
    wr_cfg(1, 4, 2);
    chk_mode(1, 4, "R1 rising");
    src[0] = 1;
    step(6);
    chk_quiet("R3 disabled source");
    set_en(1);
    rd_id = 4'd1; #1;
    chk(rd_en == 1'b1, "R3 enable bit", rd_en, 1);
    @(negedge clk);
    chk(msg_valid == 1'b0, "R3 enable latency early", msg_valid, 0);
    step();
    @(negedge clk);
    chk(msg_valid == 1'b1, "R3 enable latency", msg_valid, 1);
    chk(msg_id == 4'd1, "R12 id", msg_id, 1);
    chk(msg_hart == 3'd2, "R12 hart", msg_hart, 2);
    expect_msg(1, 2, "R5 first edge");
    step();
    msg_ready = 1;
    step(8);

    // R5 latency: new edge, valid on 4th edge
    src[0] = 0;
    step(5);
    msg_ready = 0;
    expect_msg(1, 2, "R5 second edge");
    src[0] = 1;
    step(3);
    @(negedge clk);
    chk(msg_valid == 1'b0, "R5 latency early", msg_valid, 0);
    step();
    @(negedge clk);
    chk(msg_valid == 1'b1, "R5 latency due", msg_valid, 1);
    step();
    msg_ready = 1;
    step(8);

    // R6 falling edge
    set_en(2);
    src[1] = 1;
    step(8);
    expect_msg(2, 1, "R6 falling");
    src[1] = 0;
    step(8);

    // R7 level high: one message per assertion
    wr_cfg(3, 6, 5);
    set_en(3);
    expect_msg(3, 5, "R7 high first");
    src[2] = 1;
    step(14);
    src[2] = 0;
    step(5);
    expect_msg(3, 5, "R7 high again");
    src[2] = 1;
    step(8);
    src[2] = 0;
    step(4);

    // R7 level low
    src[3] = 1;
    wr_cfg(4, 7, 0);
    set_en(4);
    step(6);
    chk_quiet("R7 low inactive");
    expect_msg(4, 0, "R7 low");
    src[3] = 0;
    step(8);
    src[3] = 1;
    step(4);

    // R8 detached: wire ignored, set-pending works
    wr_cfg(5, 1, 4);
    set_en(5);
    src[4] = 1;
    step(6);
    src[4] = 0;
    step(6);
    chk_quiet("R8 wire ignored");
    expect_msg(5, 4, "R8 set-pending");
    set_pend(5);
    step(5);
    set_pend(1);
    step(6);
    chk_quiet("R8 set-pending on edge mode");

    // R9 off source
    set_en(6);
    src[5] = 1;
    step(6);
    src[5] = 0;
    set_pend(6);
    step(6);
    chk_quiet("R9 off source");

    // R4 domain gating
    wr_dom(0, 1);
    set_pend(5);
    step(6);
    chk_quiet("R4 global enable off");
    wr_dom(1, 0);
    step(6);
    chk_quiet("R4 delivery mode off");
    expect_msg(5, 4, "R4 released");
    wr_dom(1, 1);
    step(5);

    // R10 priority and R11 back-pressure
    wr_dom(0, 1);
    wr_cfg(9, 1, 6);
    wr_cfg(7, 1, 3);
    set_en(9);
    set_en(7);
    set_pend(9);
    set_pend(7);
    msg_ready = 0;
    expect_msg(7, 3, "R10 lowest first");
    expect_msg(9, 6, "R10 second");
    wr_dom(1, 1);
    step();
    @(negedge clk);
    chk(msg_valid == 1'b1 && msg_id == 4'd7, "R10 lowest id", msg_id, 7);
    step(4);
    @(negedge clk);
    chk(msg_valid == 1'b1, "R11 held valid", msg_valid, 1);
    chk(msg_id == 4'd7, "R11 held id", msg_id, 7);
    chk(msg_hart == 3'd3, "R11 held hart", msg_hart, 3);
    step();
    msg_ready = 1;
    step();
    @(negedge clk);
    chk(msg_valid == 1'b0, "R11 gap cycle", msg_valid, 1'b0);
    step();
    @(negedge clk);
    chk(msg_valid == 1'b1 && msg_id == 4'd9, "R10 next id", msg_id, 9);
    step(4);

    // R2 out-of-range identities and top identity
    wr_cfg(8, 1, 7);
    set_pend(8);
    set_en(0);
    set_en(13);
    set_en(15);
    set_pend(0);
    set_pend(14);
    step(6);
    chk_quiet("R2 out-of-range enable");
    rd_id = 4'd8; #1;
    chk(rd_en == 1'b0, "R2 slot 8 untouched", rd_en, 0);
    wr_cfg(13, 4, 1);
    chk_mode(13, 0, "R2 read beyond range");
    wr_cfg(0, 6, 1);
    chk_mode(0, 0, "R2 identity zero");
    wr_cfg(12, 1, 1);
    chk_mode(12, 1, "R2 top identity mode");
    set_en(12);
    expect_msg(12, 1, "R2 top identity");
    set_pend(12);
    step(6);

    chk(exp_q.size() == 0, "R12 all expected messages seen", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule